// File: doc/BRIEF.md
# Instruction Opcode Dispatcher

This block sits between an instruction front end and five compute engines. It takes 64-bit instruction words from a valid/ready stream and reads the top four bits as the opcode. The lower sixty bits are the body, and the block places the body in a first-in first-out queue owned by the engine that the opcode selects. The five engines are vector-matrix multiply, matrix-matrix multiply, memory copy, constant-cache write and element-wise non-linear. Each engine drains its own queue through its own valid/ready pair, so engines run independently of one another.

Back-pressure follows one rule. The input stream stalls (`in_ready` low) only while the word at its head is legal and its target queue is full. A word bound for any other queue is accepted in that same situation. Words with an undefined opcode are always accepted and then discarded, and each one produces a single-cycle flag. Each queue has a parameter depth and reports its occupancy as a plain status output. On each engine port a transfer happens on a cycle where both valid and ready are high.

Top module: `instr_dispatch`

## Requirements
- R1: The opcode is `in_instr[63:60]` and the body is `in_instr[59:0]`. Opcode 0 routes to engine 0 (vector-matrix), 1 to engine 1 (matrix-matrix), 2 to engine 2 (memory copy), 3 to engine 3 (constant write) and 4 to engine 4 (non-linear). Engine i presents the body unchanged on `eng_body[i*60 +: 60]`.
- R2: A body accepted on a clock edge is visible on its engine port (`eng_valid[i]` high) from that edge onward, so the latency is one cycle. It is never visible on the same edge it is accepted.
- R3: Opcodes 5 to 15 are accepted no matter how full the queues are, are written to no queue, and drive `illegal_pulse` high for exactly the one cycle that follows acceptance.
- R4: `in_ready` is low only when the head word is legal and its target queue holds DEPTH entries. A full queue does not accept a pop and a push in the same cycle.
- R5: While one queue is full or its engine holds ready low, words for the other queues are still accepted and delivered.
- R6: Each engine receives its bodies in the order they were accepted.
- R7: `eng_count[i*CW +: CW]` equals the occupancy of queue i, where CW = clog2(DEPTH+1). A push and a pop on the same queue in the same cycle leave the count unchanged.
- R8: After reset all counts are zero, all `eng_valid` bits are low, `illegal_pulse` is low and `in_ready` is high.
- R9: `eng_valid[i]` is high exactly when queue i is non-empty. A pop happens only when valid and ready are both high, so `eng_ready` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Dispatcher can accept the head word |
| in_instr | input | 64 | Opcode [63:60] and body [59:0] |
| eng_valid | output | 5 | Per-engine queue non-empty |
| eng_ready | input | 5 | Per-engine pop request |
| eng_body | output | 300 | Head body of each queue, 60 bits per engine |
| eng_count | output | 5*CW | Occupancy of each queue, CW bits per engine |
| illegal_pulse | output | 1 | One-cycle flag for a discarded undefined opcode |

## Verification
A single queue can be written by the front end and read by its engine on the same clock edge. The bench provokes this by presenting an opcode-4 word while engine 4 holds ready with one entry already queued. It then checks that the occupancy stays at one and that the head has advanced to the newer body. A second collision places a full queue next to traffic for a different queue and next to an undefined opcode. In that case the bench checks that `in_ready` stays high for everything except the word aimed at the full queue.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int INSTR_W = 64;
  localparam int OPC_W   = 4;
  localparam int BODY_W  = INSTR_W - OPC_W;
  localparam int NUM_ENG = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_VMUL  = 4'd0,
    OPC_MMUL  = 4'd1,
    OPC_COPY  = 4'd2,
    OPC_CONST = 4'd3,
    OPC_NLIN  = 4'd4
  } opcode_e;

  typedef logic [BODY_W-1:0] body_t;
endpackage

// File: rtl/opcode_decode.sv
module opcode_decode
  import dispatch_pkg::*;
(
  input  logic [OPC_W-1:0]   opc,
  output logic [NUM_ENG-1:0] sel,
  output logic               legal
);
  // One select line per engine; the engine index equals the opcode value.
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_ENG; i++) begin
      if (opc == OPC_W'(i)) sel[i] = 1'b1;
    end
    legal = |sel;
  end
endmodule

// File: rtl/dispatch_fifo.sv
module dispatch_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 60,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  // R4: the front end never writes into a full queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: no read from an empty queue
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: simultaneous write and read keep occupancy
  p_count_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count == $past(count));
endmodule

// File: rtl/instr_dispatch.sv
module instr_dispatch
  import dispatch_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [INSTR_W-1:0]         in_instr,
  output logic [NUM_ENG-1:0]         eng_valid,
  input  logic [NUM_ENG-1:0]         eng_ready,
  output logic [NUM_ENG*BODY_W-1:0]  eng_body,
  output logic [NUM_ENG*CNT_W-1:0]   eng_count,
  output logic                       illegal_pulse
);
  logic [OPC_W-1:0]   opc;
  body_t              body;
  logic [NUM_ENG-1:0] sel, full_vec, empty_vec, push_vec, pop_vec;
  logic               legal, accept;

  assign opc  = in_instr[INSTR_W-1 -: OPC_W];
  assign body = in_instr[BODY_W-1:0];

  opcode_decode u_dec (.opc(opc), .sel(sel), .legal(legal));

  // Stall only on a legal word whose own queue is full.
  assign in_ready = !legal || !(|(sel & full_vec));
  assign accept   = in_valid && in_ready;
  assign push_vec = sel & {NUM_ENG{accept}};
  assign pop_vec  = eng_valid & eng_ready;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    dispatch_fifo #(.DEPTH(DEPTH), .WIDTH(BODY_W)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[g]),
      .din   (body),
      .full  (full_vec[g]),
      .pop   (pop_vec[g]),
      .dout  (eng_body[g*BODY_W +: BODY_W]),
      .empty (empty_vec[g]),
      .count (eng_count[g*CNT_W +: CNT_W])
    );
    assign eng_valid[g] = !empty_vec[g];

    // R4: a stall on opcode g implies queue g is at capacity
    p_stall_only_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_W'(g) && !in_ready) |-> eng_count[g*CNT_W +: CNT_W] == CNT_W'(DEPTH));
    // R5: spare room in queue g always admits a word for it
    p_isolation_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_W'(g) && eng_count[g*CNT_W +: CNT_W] < CNT_W'(DEPTH)) |-> in_ready);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_pulse <= 1'b0;
    else        illegal_pulse <= in_valid && !legal;
  end

  // R3: undefined opcodes never stall and raise the flag next cycle
  p_illegal_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opc > OPC_W'(NUM_ENG - 1)) |-> in_ready);
  p_illegal_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc > OPC_W'(NUM_ENG - 1)) |=> illegal_pulse);
  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc < OPC_W'(NUM_ENG)) |=> !illegal_pulse);
endmodule

// File: tb/tb_instr_dispatch.sv
module tb_instr_dispatch;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = 60;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [63:0]   in_instr;
  logic [4:0]    eng_valid;
  logic [4:0]    eng_ready;
  logic [5*BW-1:0] eng_body;
  logic [5*CW-1:0] eng_count;
  logic          illegal_pulse;

  int checks = 0;
  int errors = 0;

  instr_dispatch #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_body(eng_body), .eng_count(eng_count), .illegal_pulse(illegal_pulse)
  );

  always #5 clk = ~clk;

  function automatic logic [BW-1:0] body_of(input int e);
    return eng_body[e*BW +: BW];
  endfunction
  function automatic int cnt_of(input int e);
    return int'(eng_count[e*CW +: CW]);
  endfunction
  function automatic logic [BW-1:0] mk(input int e, input int k);
    return {28'hA5C3_0F1, 4'(e), 28'(k * 7 + 3)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a word at the falling edge, let the rising edge take it, release.
  task automatic send(input logic [3:0] op, input logic [BW-1:0] b);
    in_valid = 1'b1;
    in_instr = {op, b};
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_all();
    eng_ready = 5'h1F;
    for (int n = 0; n < DEPTH + 1; n++) @(negedge clk);
    eng_ready = 5'h00;
  endtask

  task automatic t_reset();
    check("R8 counts", 64'(eng_count), 64'd0);
    check("R8 valid", 64'(eng_valid), 64'd0);
    check("R8 illegal", 64'(illegal_pulse), 64'd0);
    check("R8 ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_route();
    for (int e = 0; e < 5; e++) begin
      in_valid = 1'b1;
      in_instr = {4'(e), mk(e, 0)};
      @(posedge clk);
      #1;
      check("R2 not same edge", 64'(eng_valid[e]), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 body", 64'(body_of(e)), 64'(mk(e, 0)));
      check("R2 valid", 64'(eng_valid[e]), 64'd1);
      check("R7 count", 64'(cnt_of(e)), 64'd1);
    end
    check("R1 all valid", 64'(eng_valid), 64'h1F);
    eng_ready = 5'h1F;
    @(negedge clk);
    eng_ready = 5'h00;
    check("R9 drained", 64'(eng_valid), 64'd0);
  endtask

  task automatic t_empty_pop();
    eng_ready = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    eng_ready = 5'h00;
    check("R9 empty pop", 64'(eng_count), 64'd0);
  endtask

  task automatic t_illegal();
    in_valid = 1'b1;
    in_instr = {4'd7, mk(1, 9)};
    check("R3 ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_instr = {4'd1, mk(1, 9)};
    check("R3 pulse", 64'(illegal_pulse), 64'd1);
    check("R3 no write", 64'(eng_count), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 one cycle", 64'(illegal_pulse), 64'd0);
    check("R3 legal follows", 64'(cnt_of(1)), 64'd1);
    drain_all();
  endtask

  task automatic t_full_isolation();
    for (int k = 0; k < DEPTH; k++) send(4'd2, mk(2, k));
    check("R7 full count", 64'(cnt_of(2)), 64'(DEPTH));
    in_valid = 1'b1;
    in_instr = {4'd2, mk(2, 99)};
    #1;
    check("R4 stall", 64'(in_ready), 64'd0);
    @(negedge clk);
    check("R4 no push", 64'(cnt_of(2)), 64'(DEPTH));
    in_instr = {4'd0, mk(0, 5)};
    #1;
    check("R5 other ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    check("R5 other delivered", 64'(body_of(0)), 64'(mk(0, 5)));
    in_instr = {4'd15, mk(0, 6)};
    #1;
    check("R3 ready while full", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 flag while full", 64'(illegal_pulse), 64'd1);
    eng_ready = 5'b00100;
    for (int k = 0; k < DEPTH; k++) begin
      check("R6 order", 64'(body_of(2)), 64'(mk(2, k)));
      @(negedge clk);
    end
    eng_ready = 5'h00;
    check("R6 emptied", 64'(cnt_of(2)), 64'd0);
    drain_all();
  endtask

  task automatic t_simultaneous();
    send(4'd4, mk(4, 1));
    in_valid  = 1'b1;
    in_instr  = {4'd4, mk(4, 2)};
    eng_ready = 5'b10000;
    @(negedge clk);
    in_valid  = 1'b0;
    eng_ready = 5'h00;
    check("R7 push+pop count", 64'(cnt_of(4)), 64'd1);
    check("R7 push+pop head", 64'(body_of(4)), 64'(mk(4, 2)));
    drain_all();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_instr = '0;
    eng_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_empty_pop();
    t_illegal();
    t_full_isolation();
    t_simultaneous();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule